// File: doc/BRIEF.md
# Max-Log Soft-Output Extrinsic Stage

This block produces the extrinsic soft value for one trellis step of an 8-state max-log MAP component decoder. Each accepted item carries three sets of metrics: the normalized forward metrics of step k, the normalized backward metrics of step k+1, and a packed word of branch metrics. It also carries the systematic channel value and the a-priori value for the same bit. The block forms all sixteen path sums. It takes the best sum among the branches driven by input bit 1 and the best among those driven by input bit 0, and subtracts the second from the first to get the log-likelihood ratio. It then removes the systematic and a-priori parts and clamps what is left to a 6-bit word.

The work is split across three register stages. Stage one forms the path sums, stage two cuts each group of eight down to two candidates, and stage three finishes the maximum, the subtraction and the clamp. Both edges of the block are valid/ready streams. An item moves across an edge on any rising clock edge where valid and ready are both high. The pipeline advances as one unit, and it holds whenever its last stage has a result that the consumer has not taken. While it holds, `in_ready` is low and the output stays frozen. No item is dropped and none is duplicated, and results leave in the order the inputs arrived.

Top module: `llr_extrinsic_unit`

## Requirements
- R1: For each item, LLR = max over bit-1 branches of P(s,1) minus max over bit-0 branches of P(s,0). Here P(s,u) = alpha(s) + beta(next(s,u)) + gamma(s,u), using signed arithmetic and no loss of precision.
- R2: The trellis has states s = {s2,s1,s0}. A branch from s with input u goes to next(s,u) = {s1, s0, u^s2^s1}. Its branch metric is taken from field j = s0 + s2 of the packed branch word.
- R3: The packed branch word holds three signed 6-bit fields, with field j at bits [6j+5:6j]. A bit-1 branch uses +field j. A bit-0 branch uses the negation of field j, and that negation is exact even for the value -32.
- R4: Forward and backward metrics arrive as seven signed 7-bit values for states 1 to 7, with state m at bits [7m-1:7m-7]. The metric of state 0 is always taken as zero.
- R5: The wide extrinsic value is LLR minus the signed 4-bit systematic value minus the signed 6-bit a-priori value, computed without overflow.
- R6: `out_ext` is the wide extrinsic value clamped to the range -32..31, in two's complement. Values inside the range pass through unchanged, including both limits.
- R7: With `out_ready` held high, an item accepted at clock edge t appears with `out_valid` high after edge t+2, and the block accepts a new item on every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_ext` stay unchanged. Every accepted item leaves exactly once, in order.
- R9: During and right after reset (active-low `rst_n`), `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_alpha | input | 49 | Forward metrics of states 1..7 at step k |
| in_beta | input | 49 | Backward metrics of states 1..7 at step k+1 |
| in_gamma | input | 18 | Three packed signed branch metrics |
| in_sys | input | 4 | Signed systematic channel value |
| in_apri | input | 6 | Signed a-priori value |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item |
| out_ext | output | 6 | Saturated signed extrinsic value |

## Verification
The bench probes the clamp at 31 and 32 and at -32 and -33. A clamp that is off by one, or that checks the wrong sign, returns a wrapped or shifted word at these points. A vector that uses only one branch field exposes a negation that is wrong or that wraps at -32, because the LLR then comes out with the wrong magnitude. Vectors that load single-state metrics expose a transition table or a field selection that is wired wrong. Random bursts with a consumer that often deasserts ready catch stalls that drop, repeat or reorder items, or that let the output change while it waits.

// File: rtl/llr_pkg.sv
package llr_pkg;
  // Trellis of the 8-state recursive component code
  localparam int NSTATE = 8;
  localparam int SBITS  = 3;
  localparam int NFIELD = 3;   // distinct packed branch metrics

  // Successor state of a branch leaving s on input bit u
  function automatic logic [SBITS-1:0] next_state(input logic [SBITS-1:0] s, input logic u);
    return {s[1:0], u ^ s[2] ^ s[1]};
  endfunction

  // Branch metric field used by the two branches leaving s
  function automatic int field_sel(input logic [SBITS-1:0] s);
    return int'(s[0]) + int'(s[2]);
  endfunction
endpackage

// File: rtl/llr_branch_stage.sv
module llr_branch_stage import llr_pkg::*; #(
  parameter int MW = 7,
  parameter int GW = 6,
  parameter int SW = 9
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [(NSTATE-1)*MW-1:0]      alpha_i,
  input  logic [(NSTATE-1)*MW-1:0]      beta_i,
  input  logic [NFIELD*GW-1:0]          gamma_i,
  output logic [NSTATE-1:0][SW-1:0]     sum1_o,
  output logic [NSTATE-1:0][SW-1:0]     sum0_o
);
  logic signed [SW-1:0] am [NSTATE];
  logic signed [SW-1:0] bm [NSTATE];
  logic signed [SW-1:0] gp [NFIELD];
  logic signed [SW-1:0] p1 [NSTATE];
  logic signed [SW-1:0] p0 [NSTATE];

  // Unpack metrics; state 0 is the normalization reference
  always_comb begin
    am[0] = '0;
    bm[0] = '0;
    for (int m = 1; m < NSTATE; m++) begin
      am[m] = SW'($signed(alpha_i[(m-1)*MW +: MW]));
      bm[m] = SW'($signed(beta_i[(m-1)*MW +: MW]));
    end
    for (int j = 0; j < NFIELD; j++) begin
      gp[j] = SW'($signed(gamma_i[j*GW +: GW]));
    end
  end

  // One adder pair per branch; bit-0 branch uses the negated field
  for (genvar s = 0; s < NSTATE; s++) begin : g_state
    localparam logic [SBITS-1:0] NXT1 = next_state(SBITS'(s), 1'b1);
    localparam logic [SBITS-1:0] NXT0 = next_state(SBITS'(s), 1'b0);
    localparam int               FJ   = field_sel(SBITS'(s));
    assign p1[s] = am[s] + bm[NXT1] + gp[FJ];
    assign p0[s] = am[s] + bm[NXT0] - gp[FJ];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum1_o <= '0;
      sum0_o <= '0;
    end else if (en) begin
      for (int s = 0; s < NSTATE; s++) begin
        sum1_o[s] <= p1[s];
        sum0_o[s] <= p0[s];
      end
    end
  end
endmodule

// File: rtl/llr_max_reduce.sv
module llr_max_reduce #(
  parameter int W    = 9,
  parameter int NIN  = 8,
  parameter int NOUT = 2
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NIN-1:0][W-1:0] d_i,
  output logic [NOUT-1:0][W-1:0] q_o
);
  localparam int PER = NIN / NOUT;

  logic signed [W-1:0] best [NOUT];

  // Each output lane keeps the largest of its PER inputs
  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      best[o] = $signed(d_i[o*PER]);
      for (int k = 1; k < PER; k++) begin
        if ($signed(d_i[o*PER+k]) > best[o]) best[o] = $signed(d_i[o*PER+k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (en) begin
      for (int o = 0; o < NOUT; o++) q_o[o] <= best[o];
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    AST_MAX_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n) // R1
      (rst_n && en) |=> ($signed(q_o[i/PER]) >= $signed($past(d_i[i]))))
      else $error("candidate below one of its inputs");
  end
endmodule

// File: rtl/llr_finish.sv
module llr_finish #(
  parameter int SW   = 9,
  parameter int CAND = 2,
  parameter int SYW  = 4,
  parameter int APW  = 6,
  parameter int EW   = 6
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [CAND-1:0][SW-1:0] c1_i,
  input  logic [CAND-1:0][SW-1:0] c0_i,
  input  logic [SYW-1:0]          sys_i,
  input  logic [APW-1:0]          apri_i,
  output logic [EW-1:0]           ext_o
);
  localparam int WW = SW + 3;
  localparam logic signed [WW-1:0] HI = WW'(2**(EW-1) - 1);
  localparam logic signed [WW-1:0] LO = WW'(-(2**(EW-1)));

  logic signed [WW-1:0] m1, m0, wide;
  logic [EW-1:0]        sat;

  always_comb begin
    m1 = WW'($signed(c1_i[0]));
    m0 = WW'($signed(c0_i[0]));
    for (int k = 1; k < CAND; k++) begin
      if (WW'($signed(c1_i[k])) > m1) m1 = WW'($signed(c1_i[k]));
      if (WW'($signed(c0_i[k])) > m0) m0 = WW'($signed(c0_i[k]));
    end
    wide = m1 - m0 - WW'($signed(sys_i)) - WW'($signed(apri_i));
    if (wide > HI)      sat = HI[EW-1:0];
    else if (wide < LO) sat = LO[EW-1:0];
    else                sat = wide[EW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  ext_o <= '0;
    else if (en) ext_o <= sat;
  end

  AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (rst_n && en) |=> (ext_o[EW-1] == $past(wide[WW-1])))
    else $error("clamped output sign differs from wide value");
endmodule

// File: rtl/llr_extrinsic_unit.sv
module llr_extrinsic_unit import llr_pkg::*; #(
  parameter int MW  = 7,
  parameter int GW  = 6,
  parameter int SYW = 4,
  parameter int APW = 6,
  parameter int EW  = 6
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [(NSTATE-1)*MW-1:0] in_alpha,
  input  logic [(NSTATE-1)*MW-1:0] in_beta,
  input  logic [NFIELD*GW-1:0]     in_gamma,
  input  logic [SYW-1:0]           in_sys,
  input  logic [APW-1:0]           in_apri,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [EW-1:0]            out_ext
);
  localparam int SW   = ((MW > GW) ? MW : GW) + 2;
  localparam int CAND = 2;

  logic en;
  logic v1, v2, v3;
  logic [SYW-1:0] sys1, sys2;
  logic [APW-1:0] apr1, apr2;
  logic [NSTATE-1:0][SW-1:0] sums  [2];
  logic [CAND-1:0][SW-1:0]   cands [2];

  // Whole pipe moves unless a finished result is waiting
  assign en        = ~(v3 & ~out_ready);
  assign in_ready  = en;
  assign out_valid = v3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      sys1 <= '0; sys2 <= '0; apr1 <= '0; apr2 <= '0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      sys1 <= in_sys;
      apr1 <= in_apri;
      sys2 <= sys1;
      apr2 <= apr1;
    end
  end

  llr_branch_stage #(.MW(MW), .GW(GW), .SW(SW)) u_branch (
    .clk(clk), .rst_n(rst_n), .en(en),
    .alpha_i(in_alpha), .beta_i(in_beta), .gamma_i(in_gamma),
    .sum1_o(sums[1]), .sum0_o(sums[0])
  );

  for (genvar g = 0; g < 2; g++) begin : g_grp
    llr_max_reduce #(.W(SW), .NIN(NSTATE), .NOUT(CAND)) u_reduce (
      .clk(clk), .rst_n(rst_n), .en(en),
      .d_i(sums[g]), .q_o(cands[g])
    );
  end

  llr_finish #(.SW(SW), .CAND(CAND), .SYW(SYW), .APW(APW), .EW(EW)) u_finish (
    .clk(clk), .rst_n(rst_n), .en(en),
    .c1_i(cands[1]), .c0_i(cands[0]),
    .sys_i(sys2), .apri_i(apr2),
    .ext_o(out_ext)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R8
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ext)))
    else $error("output changed while waiting");

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) // R7
    ($past(rst_n,3) && $past(rst_n,2) && $past(rst_n,1) &&
     $past(in_valid && in_ready,3) && $past(out_ready,2) && $past(out_ready,1)) |-> out_valid)
    else $error("accepted item missing after three edges");

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) // R9
    $rose(rst_n) |-> (!out_valid && in_ready))
    else $error("not idle on reset release");
endmodule

// File: tb/tb_llr_extrinsic_unit.sv
module tb_llr_extrinsic_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [48:0] in_alpha = '0;
  logic [48:0] in_beta = '0;
  logic [17:0] in_gamma = '0;
  logic [3:0]  in_sys = '0;
  logic [5:0]  in_apri = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  out_ext;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  llr_extrinsic_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_alpha(in_alpha), .in_beta(in_beta), .in_gamma(in_gamma),
    .in_sys(in_sys), .in_apri(in_apri),
    .out_valid(out_valid), .out_ready(out_ready), .out_ext(out_ext)
  );

  // Reference built from R1..R6
  function automatic logic [5:0] ref_ext(input logic [48:0] a, input logic [48:0] b,
                                         input logic [17:0] g, input logic [3:0] sy,
                                         input logic [5:0] ap);
    int am [8];
    int bm [8];
    int gv [3];
    int best1, best0, e;
    am[0] = 0; bm[0] = 0;
    for (int m = 1; m < 8; m++) begin
      am[m] = $signed(a[(m-1)*7 +: 7]);
      bm[m] = $signed(b[(m-1)*7 +: 7]);
    end
    for (int j = 0; j < 3; j++) gv[j] = $signed(g[j*6 +: 6]);
    best1 = -100000; best0 = -100000;
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 2; u++) begin
        int ns, j, p;
        ns = ((s & 3) << 1) | (u ^ ((s >> 2) & 1) ^ ((s >> 1) & 1));
        j  = (s & 1) + ((s >> 2) & 1);
        p  = am[s] + bm[ns] + (u == 1 ? gv[j] : -gv[j]);
        if (u == 1 && p > best1) best1 = p;
        if (u == 0 && p > best0) best0 = p;
      end
    end
    e = best1 - best0 - int'($signed(sy)) - int'($signed(ap));
    if (e > 31)  e = 31;
    if (e < -32) e = -32;
    return 6'(e);
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(act), $signed(exp_v));
    end
  endtask

  task automatic send(input string req, input logic [48:0] a, input logic [48:0] b,
                      input logic [17:0] g, input logic [3:0] sy, input logic [5:0] ap);
    @(negedge clk);
    in_valid = 1'b1; in_alpha = a; in_beta = b; in_gamma = g; in_sys = sy; in_apri = ap;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(ref_ext(a, b, g, sy, ap));
    tag_q.push_back(req);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Back-pressure source
  always @(negedge clk) out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;

  // Monitor / scoreboard
  bit         held = 1'b0;
  logic [5:0] held_val;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held) begin
        checks++;
        if (!out_valid || out_ext !== held_val) begin
          fails++;
          $display("FAIL R8: held item changed, got valid=%0d ext=%0d expected valid=1 ext=%0d",
                   out_valid, $signed(out_ext), $signed(held_val));
        end
      end
      if (out_valid && !out_ready) begin
        check("R8 in_ready low in stall", 6'(in_ready), 6'd0);
        held = 1'b1; held_val = out_ext;
      end else begin
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8: unexpected output %0d, expected none", $signed(out_ext));
        end else begin
          check(tag_q.pop_front(), out_ext, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [48:0] z49;
    z49 = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 out_valid in reset", 6'(out_valid), 6'd0);
    check("R9 in_ready in reset", 6'(in_ready), 6'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 out_valid after reset", 6'(out_valid), 6'd0);

    // R7 latency: single item
    send("R5 zero metrics", z49, z49, '0, 4'd3, 6'd5);
    idle();
    @(negedge clk); #1;
    check("R7 not yet after 1 edge", 6'(out_valid), 6'd0);
    @(negedge clk); #1;
    check("R7 not yet after 2 edges", 6'(out_valid), 6'd0);
    @(negedge clk); #1;
    check("R7 valid after 3 edges", 6'(out_valid), 6'd1);

    // R6 clamp boundaries
    send("R6 exactly 31", z49, z49, '0, 4'd0, 6'(-31));
    send("R6 32 clamps to 31", z49, z49, '0, 4'd0, 6'(-32));
    send("R6 exactly -32", z49, z49, '0, 4'd1, 6'd31);
    send("R6 -33 clamps to -32", z49, z49, '0, 4'd2, 6'd31);
    send("R6 large positive", {7{7'd63}}, {7{7'd63}}, {6'd31, 6'd31, 6'd31}, 4'd0, 6'd0);
    send("R6 large negative", {7{7'd63}}, {7{7'd63}}, {6'(-32), 6'(-32), 6'(-32)}, 4'd7, 6'd31);
    // R3 single field and negation of -32
    send("R3 field0 only", z49, z49, {6'd0, 6'd0, 6'd20}, 4'd0, 6'd0);
    send("R3 field1 only", z49, z49, {6'd0, 6'(-13), 6'd0}, 4'd0, 6'd0);
    send("R3 field2 -32", z49, z49, {6'(-32), 6'd0, 6'd0}, 4'd0, 6'd0);
    // R2 and R4 single-state metrics
    for (int m = 1; m < 8; m++) begin
      logic [48:0] a, b;
      a = '0; b = '0;
      a[(m-1)*7 +: 7] = 7'd40;
      b[((m*3)%7)*7 +: 7] = 7'(-25);
      send("R2 R4 single state", a, b, {6'd3, 6'(-7), 6'd11}, 4'd0, 6'd0);
    end
    send("R4 state0 reference", {7{7'(-64)}}, {7{7'(-64)}}, {6'd5, 6'd9, 6'd2}, 4'(-8), 6'(-1));
    // R1 random back-to-back
    for (int n = 0; n < 40; n++) begin
      send("R1 random", 49'({$urandom, $urandom}), 49'({$urandom, $urandom}),
           18'($urandom), 4'($urandom), 6'($urandom));
    end
    // R8 random with back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 60; n++) begin
      send("R8 random stalled", 49'({$urandom, $urandom}), 49'({$urandom, $urandom}),
           18'($urandom), 4'($urandom), 6'($urandom));
      if (n % 7 == 3) begin
        idle();
        @(negedge clk);
      end
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R8 drained", 6'(out_valid), 6'd0);
    finish_run();
  end
endmodule